// File: doc/BRIEF.md
# Dual-Channel Converter Shutdown Controller

This block keeps track of the power state of two converter output channels and of the bias generator and reference they share. It takes single-cycle command strobes that a serial command decoder has already produced: shut down one channel or both, each with its own load-select bit; full power-down; and a register-update event per channel. It also takes an active-low lockout input that blocks every power-reduction command. For each channel it reports whether the channel is active or shut down, and which termination it uses while shut down. It also reports whether the bias and reference are enabled, and whether each channel's output has had time to settle after its last wake-up.

A channel leaves shutdown when its data register is updated or when the lockout input falls. Full power-down is left only by waking a channel, and that wake-up also restores the bias. The settle flag is held low for a long window after power-up or after leaving full power-down. It is held low for a shorter window after leaving a plain channel shutdown. Both windows are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `dual_sd_ctrl`

## Requirements
- R1: After reset both channels read active (code 00), bias_en is 1, and both settled flags are 0; each settled flag rises LONG cycles after reset is released, where LONG = CLK_HZ/1000*LONG_US/1000.
- R2: Channel mode codes are 00 active, 01 shut down with the low-ohm load (load-select 0) and 10 shut down with the high-ohm load (load-select 1). Code 11 never appears. A shutdown strobe for one channel changes only that channel, one cycle after the strobe. The both-channels strobe shuts down both, each with its own load-select bit.
- R3: A full power-down strobe clears bias_en and shuts down both channels, each with its own load-select bit. Whenever bias_en is 0, neither channel is active.
- R4: An update strobe for a shut-down channel makes it active on the next cycle and leaves the other channel unchanged. An update strobe for an active channel changes neither its mode nor its settled flag.
- R5: Waking either channel while bias_en is 0 sets bias_en to 1 on the same cycle. The other channel stays shut down.
- R6: While bias_en is 0, shutdown strobes may change the load codes, but bias_en stays 0.
- R7: While lockout_n is 0, shutdown and full power-down strobes have no effect on the modes or on bias_en.
- R8: A 1-to-0 transition of lockout_n while any channel is shut down makes both channels active and sets bias_en to 1 on the next cycle.
- R9: A wake of a channel drives its settled flag low. The flag returns high LONG cycles later if bias_en was 0 before the wake, and SHORT cycles later (SHORT = CLK_HZ/1000*SHORT_US/1000) if it was 1. A later wake restarts the count. A shut-down channel reads settled 0.
- R10: When an update strobe and a shutdown or full power-down strobe reach the same channel in the same cycle, the update wins and the channel is active afterwards. Bias then stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_a_stb | input | 1 | Shut down channel A |
| sd_b_stb | input | 1 | Shut down channel B |
| sd_both_stb | input | 1 | Shut down both channels |
| full_pd_stb | input | 1 | Full power-down including bias and reference |
| load_sel_a | input | 1 | Channel A termination in shutdown (0 low-ohm, 1 high-ohm) |
| load_sel_b | input | 1 | Channel B termination in shutdown |
| upd_a_stb | input | 1 | Channel A data register update |
| upd_b_stb | input | 1 | Channel B data register update |
| lockout_n | input | 1 | Active-low shutdown lockout; its falling edge forces a wake |
| mode_a | output | 2 | Channel A power mode |
| mode_b | output | 2 | Channel B power mode |
| bias_en | output | 1 | Bias generator and reference enable |
| settled_a | output | 1 | Channel A output has settled |
| settled_b | output | 1 | Channel B output has settled |

## Verification
A wrong mode or bias bit shows on mode_a, mode_b or bias_en one cycle after the strobe that caused it. The reference model compares these outputs on every cycle, so such an error is caught at once. A wrong choice of settle window, or a timer that fails to restart, shows only when a settled flag rises. That can be up to LONG cycles after the wake, at the cycle where the model expects the flag to change. Lockout errors appear only on the cycle after a falling edge or a blocked strobe, so the scenarios put strobes exactly on those cycles.

// File: rtl/dual_sd_ctrl.sv
module dual_sd_ctrl #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int LONG_US  = 400,
  parameter int SHORT_US = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sd_a_stb,
  input  logic       sd_b_stb,
  input  logic       sd_both_stb,
  input  logic       full_pd_stb,
  input  logic       load_sel_a,
  input  logic       load_sel_b,
  input  logic       upd_a_stb,
  input  logic       upd_b_stb,
  input  logic       lockout_n,
  output logic [1:0] mode_a,
  output logic [1:0] mode_b,
  output logic       bias_en,
  output logic       settled_a,
  output logic       settled_b
);

  localparam int LONG_CYC  = CLK_HZ / 1000 * LONG_US / 1000;
  localparam int SHORT_CYC = CLK_HZ / 1000 * SHORT_US / 1000;
  localparam int CW        = $clog2(LONG_CYC + 1);
  localparam logic [1:0] M_ACT = 2'b00;
  localparam logic [1:0] M_LO  = 2'b01;
  localparam logic [1:0] M_HI  = 2'b10;

  logic [1:0]    mode_q [2];
  logic [1:0]    mode_d [2];
  logic [CW-1:0] cnt_q  [2];
  logic [CW-1:0] cnt_d  [2];
  logic [1:0]    upd, sd_stb, sel, wake, sd_req;
  logic          bias_q, bias_d, lk_q, force_wake, fpd_ok;

  assign upd    = {upd_b_stb, upd_a_stb};
  assign sd_stb = {sd_b_stb, sd_a_stb};
  assign sel    = {load_sel_b, load_sel_a};
  assign fpd_ok = full_pd_stb & lockout_n;
  assign force_wake = lk_q & ~lockout_n & ((mode_q[0] != M_ACT) | (mode_q[1] != M_ACT));

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      sd_req[i] = lockout_n & (sd_stb[i] | sd_both_stb | full_pd_stb);
      wake[i]   = (mode_q[i] != M_ACT) & (upd[i] | force_wake);
      if (upd[i] | force_wake)  mode_d[i] = M_ACT;
      else if (sd_req[i])       mode_d[i] = sel[i] ? M_HI : M_LO;
      else                      mode_d[i] = mode_q[i];
      if (wake[i])              cnt_d[i] = bias_q ? CW'(SHORT_CYC) : CW'(LONG_CYC);
      else if (cnt_q[i] != '0)  cnt_d[i] = cnt_q[i] - 1'b1;
      else                      cnt_d[i] = cnt_q[i];
    end
    if (|upd | force_wake) bias_d = 1'b1;
    else if (fpd_ok)       bias_d = 1'b0;
    else                   bias_d = bias_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        mode_q[i] <= M_ACT;
        cnt_q[i]  <= CW'(LONG_CYC);
      end
      bias_q <= 1'b1;
      lk_q   <= 1'b1;
    end else begin
      for (int i = 0; i < 2; i++) begin
        mode_q[i] <= mode_d[i];
        cnt_q[i]  <= cnt_d[i];
      end
      bias_q <= bias_d;
      lk_q   <= lockout_n;
    end
  end

  assign mode_a    = mode_q[0];
  assign mode_b    = mode_q[1];
  assign bias_en   = bias_q;
  assign settled_a = (mode_q[0] == M_ACT) && (cnt_q[0] == '0);
  assign settled_b = (mode_q[1] == M_ACT) && (cnt_q[1] == '0);

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a != 2'b11) && (mode_b != 2'b11));

  assert_bias_off_all_shut_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_en |-> (mode_a != M_ACT) && (mode_b != M_ACT));

  assert_fpd_clears_bias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_pd_stb && lockout_n && !upd_a_stb && !upd_b_stb && !(lk_q && !lockout_n)) |=> !bias_en);

  assert_wake_restores_bias_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bias_en && (upd_a_stb || upd_b_stb)) |=> bias_en);

  assert_lockout_holds_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockout_n && mode_a == M_ACT) |=> mode_a == M_ACT);

  assert_lockout_holds_bias_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockout_n && bias_en) |=> bias_en);

  assert_wake_unsettles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a != M_ACT && upd_a_stb) |=> !settled_a);

  assert_update_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_b_stb |=> mode_b == M_ACT);

endmodule

// File: tb/dual_sd_ctrl_bench.sv
module dual_sd_ctrl_bench;
  localparam int HZ = 1_000_000;
  localparam int LONG = HZ / 1000 * 400 / 1000;
  localparam int SHORT = HZ / 1000 * 160 / 1000;

  logic clk = 0, rst_n = 0;
  logic sd_a_stb = 0, sd_b_stb = 0, sd_both_stb = 0, full_pd_stb = 0;
  logic load_sel_a = 0, load_sel_b = 0, upd_a_stb = 0, upd_b_stb = 0, lockout_n = 1;
  logic [1:0] mode_a, mode_b;
  logic bias_en, settled_a, settled_b;

  dual_sd_ctrl #(.CLK_HZ(HZ), .LONG_US(400), .SHORT_US(160)) u_dual_sd_ctrl (
    .clk(clk), .rst_n(rst_n), .sd_a_stb(sd_a_stb), .sd_b_stb(sd_b_stb),
    .sd_both_stb(sd_both_stb), .full_pd_stb(full_pd_stb), .load_sel_a(load_sel_a),
    .load_sel_b(load_sel_b), .upd_a_stb(upd_a_stb), .upd_b_stb(upd_b_stb),
    .lockout_n(lockout_n), .mode_a(mode_a), .mode_b(mode_b), .bias_en(bias_en),
    .settled_a(settled_a), .settled_b(settled_b));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_st [2];
  int m_cnt [2];
  int m_bias, m_lk;
  bit fw, any_upd;
  bit [1:0] u, s, l;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '{0, 0}; m_cnt = '{LONG, LONG}; m_bias = 1; m_lk = 1;
    end else begin
      u = {upd_b_stb, upd_a_stb}; s = {sd_b_stb, sd_a_stb}; l = {load_sel_b, load_sel_a};
      fw = m_lk && !lockout_n && (m_st[0] != 0 || m_st[1] != 0);
      any_upd = u[0] || u[1] || fw;
      for (int i = 0; i < 2; i++) begin
        if ((u[i] || fw) && m_st[i] != 0) begin
          m_st[i] = 0; m_cnt[i] = m_bias ? SHORT : LONG;
        end else begin
          if (m_cnt[i] > 0) m_cnt[i]--;
          if (!(u[i] || fw) && lockout_n && (s[i] || sd_both_stb || full_pd_stb))
            m_st[i] = l[i] ? 2 : 1;
        end
      end
      if (any_upd) m_bias = 1;
      else if (full_pd_stb && lockout_n) m_bias = 0;
      m_lk = lockout_n;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      checks++;
      if (mode_a !== 2'(m_st[0]) || mode_b !== 2'(m_st[1]) || bias_en !== 1'(m_bias) ||
          settled_a !== (m_st[0] == 0 && m_cnt[0] == 0) || settled_b !== (m_st[1] == 0 && m_cnt[1] == 0)) begin
        fails++;
        $display("FAIL %s cycle %0d: got a=%0d b=%0d bias=%0b st=%0b%0b expected a=%0d b=%0d bias=%0d st=%0b%0b",
          cur_req, cyc, mode_a, mode_b, bias_en, settled_a, settled_b, m_st[0], m_st[1], m_bias,
          (m_st[0] == 0 && m_cnt[0] == 0), (m_st[1] == 0 && m_cnt[1] == 0));
      end
    end
    if (cyc > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(bit sa, bit sb, bit both, bit fpd, bit la, bit lb, bit ua, bit ub);
    @(negedge clk);
    sd_a_stb = sa; sd_b_stb = sb; sd_both_stb = both; full_pd_stb = fpd;
    load_sel_a = la; load_sel_b = lb; upd_a_stb = ua; upd_b_stb = ub;
    @(negedge clk);
    sd_a_stb = 0; sd_b_stb = 0; sd_both_stb = 0; full_pd_stb = 0; upd_a_stb = 0; upd_b_stb = 0;
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1;
    cur_req = "R1";
    chk("R1 mode_a", mode_a, 0); chk("R1 bias", bias_en, 1); chk("R1 settled_a", settled_a, 0);
    idle(LONG - 2);
    chk("R1 settled early", settled_b, 0);
    idle(3);
    chk("R1 settled", settled_a & settled_b, 1);

    cur_req = "R2";
    drive(1, 0, 0, 0, 0, 1, 0, 0);
    chk("R2 a low-ohm", mode_a, 1); chk("R2 b untouched", mode_b, 0);
    drive(0, 1, 0, 0, 0, 1, 0, 0);
    chk("R2 b high-ohm", mode_b, 2); chk("R2 settled_b in sd", settled_b, 0);

    cur_req = "R4";
    drive(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R4 a woken", mode_a, 0); chk("R4 b kept", mode_b, 2);
    cur_req = "R9";
    idle(SHORT - 2);
    chk("R9 short not yet", settled_a, 0);
    idle(2);
    chk("R9 short done", settled_a, 1);
    cur_req = "R4";
    drive(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R4 active update settled", settled_a, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R4 b woken", mode_b, 0);
    idle(SHORT + 2);

    cur_req = "R7";
    @(negedge clk) lockout_n = 0;
    drive(0, 0, 1, 0, 1, 1, 0, 0);
    chk("R7 both ignored", mode_a + mode_b, 0);
    drive(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R7 fpd ignored", bias_en, 1);
    @(negedge clk) lockout_n = 1;
    idle(2);

    cur_req = "R3";
    drive(0, 0, 0, 1, 1, 0, 0, 0);
    chk("R3 bias off", bias_en, 0); chk("R3 a high-ohm", mode_a, 2); chk("R3 b low-ohm", mode_b, 1);
    cur_req = "R6";
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 a recoded", mode_a, 1); chk("R6 bias stays off", bias_en, 0);
    drive(0, 0, 1, 0, 1, 1, 0, 0);
    chk("R6 both cmd bias off", bias_en, 0);

    cur_req = "R5";
    drive(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R5 bias on", bias_en, 1); chk("R5 b active", mode_b, 0); chk("R5 a stays", mode_a, 2);
    cur_req = "R9";
    idle(LONG - 2);
    chk("R9 long not yet", settled_b, 0);
    idle(2);
    chk("R9 long done", settled_b, 1);
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 1);
    idle(50);
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 1);
    idle(SHORT - 2);
    chk("R9 restart not yet", settled_b, 0);
    idle(2);
    chk("R9 restart done", settled_b, 1);

    cur_req = "R10";
    drive(0, 1, 0, 0, 0, 1, 0, 1);
    chk("R10 update wins", mode_b, 0);
    drive(0, 0, 0, 1, 0, 0, 0, 1);
    chk("R10 fpd vs update b", mode_b, 0); chk("R10 bias kept", bias_en, 1);
    chk("R10 a shut by fpd", mode_a, 1);
    idle(SHORT + 2);

    cur_req = "R8";
    @(negedge clk) lockout_n = 0;
    idle(2);
    chk("R8 a woken by edge", mode_a, 0);
    @(negedge clk) lockout_n = 1;
    drive(0, 0, 0, 1, 1, 1, 0, 0);
    chk("R8 pre fpd", bias_en, 0);
    @(negedge clk) lockout_n = 0;
    @(negedge clk);
    chk("R8 bias back", bias_en, 1); chk("R8 both active", mode_a + mode_b, 0);
    idle(LONG + 3);
    @(negedge clk) lockout_n = 1;
    idle(3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule